// File: doc/BRIEF.md
# Compare-and-Jump Condition Unit

This block decides whether a compare-and-jump instruction transfers control, and which instruction address comes next. It compares a first source register value with a second operand. That operand is either a second register value or a short immediate taken from the instruction word. A 4-bit condition code chooses among equality, inequality, unsigned ordering and signed ordering tests.

When the test passes, the next address is the content of a dedicated jump-address register, so the block needs no offset adder. When the test fails, the next address is the current address plus one, because memory is addressed by whole words. Condition codes outside the defined set never cause a transfer and are flagged so that the core can raise a fault.

The decision logic is combinational, so an execute stage can use it in the same cycle. A registered copy of the taken decision, qualified by an evaluate strobe, is provided for the fetch stage.

Top module: `brcond_unit`

## Requirements
- R1: Condition code 4'h0 makes `taken_o` 1 for any operand values.
- R2: Code 4'h1 is taken when the two compared operands differ; code 4'h2 is taken when they are equal.
- R3: Code 4'h3 is taken when `rs1_i` is greater than the second operand as unsigned numbers; code 4'h4 when it is greater than or equal, unsigned.
- R4: Code 4'hC is taken when `rs1_i` is greater than the second operand in two's complement; code 4'hD when it is greater than or equal, signed.
- R5: With `use_imm_i` = 1 the second operand is `imm_i` sign-extended to the data width (its top bit copied into all upper bits), and `rs2_i` has no effect; with `use_imm_i` = 0 the second operand is `rs2_i`.
- R6: Codes 4'h5 to 4'hB, 4'hE and 4'hF never give `taken_o` = 1 and drive `cond_bad_o` = 1; every defined code drives `cond_bad_o` = 0.
- R7: `next_ip_o` equals `jump_addr_i` when `taken_o` is 1, otherwise `ip_i` + 1 modulo 2^ADDR_W.
- R8: `taken_q_o` after a rising clock edge equals `eval_i` AND `taken_o` as they stood at that edge; a synchronous active-high `rst` clears it to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| eval_i | input | 1 | A compare-and-jump instruction is being evaluated this cycle |
| use_imm_i | input | 1 | 1: compare against the immediate, 0: against `rs2_i` |
| cond_i | input | 4 | Condition code |
| rs1_i | input | DATA_W | First source operand |
| rs2_i | input | DATA_W | Second source operand, register form |
| imm_i | input | IMM_W | Immediate operand, immediate form |
| ip_i | input | ADDR_W | Address of the current instruction |
| jump_addr_i | input | ADDR_W | Content of the jump-address register |
| taken_o | output | 1 | Combinational branch decision |
| next_ip_o | output | ADDR_W | Combinational next instruction address |
| cond_bad_o | output | 1 | Condition code is undefined |
| taken_q_o | output | 1 | Registered decision for the fetch stage |

## Verification
The hardest situation to bring about is an immediate whose sign bit flips the result of a comparison. Only a negative immediate set against a first operand that lies between the zero-extended and the sign-extended value tells a correct extension from a plain zero fill. The vector table contains such pairs for both the unsigned and the signed tests. It also places a matching value on `rs2_i` while the immediate differs, so that a wrongly routed operand changes the outcome. The boundary between the most negative and the most positive word is applied to both the signed and the unsigned codes, and the address wrap from the all-ones value is driven directly.

// File: rtl/brcond_pkg.sv
package brcond_pkg;

  localparam int COND_W = 4;

  typedef enum logic [COND_W-1:0] {
    CC_ALWAYS = 4'h0,
    CC_NE     = 4'h1,
    CC_EQ     = 4'h2,
    CC_GTU    = 4'h3,
    CC_GEU    = 4'h4,
    CC_GTS    = 4'hC,
    CC_GES    = 4'hD
  } cond_e;

  typedef struct packed {
    logic eq;
    logic gtu;
    logic gts;
  } cmp_flags_t;

endpackage

// File: rtl/brcond_opsel.sv
module brcond_opsel #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic              use_imm_i,
  input  logic [DATA_W-1:0] rs2_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic [DATA_W-1:0] opb_o
);

  logic [DATA_W-1:0] imm_ext;

  generate
    if (IMM_W < DATA_W) begin : g_extend
      localparam int PAD_W = DATA_W - IMM_W;
      assign imm_ext = {{PAD_W{imm_i[IMM_W-1]}}, imm_i};
    end else begin : g_trunc
      assign imm_ext = imm_i[DATA_W-1:0];
    end
  endgenerate

  assign opb_o = use_imm_i ? imm_ext : rs2_i;

endmodule

// File: rtl/brcond_cmp.sv
module brcond_cmp
  import brcond_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  output cmp_flags_t        flags_o
);

  always_comb begin
    flags_o.eq  = (opa_i == opb_i);
    flags_o.gtu = (opa_i > opb_i);
    flags_o.gts = ($signed(opa_i) > $signed(opb_i));
  end

endmodule

// File: rtl/brcond_sel.sv
module brcond_sel
  import brcond_pkg::*;
(
  input  logic [COND_W-1:0] cond_i,
  input  cmp_flags_t        flags_i,
  output logic              taken_o,
  output logic              bad_o
);

  always_comb begin
    taken_o = 1'b0;
    bad_o   = 1'b0;
    case (cond_i)
      CC_ALWAYS: taken_o = 1'b1;
      CC_NE:     taken_o = !flags_i.eq;
      CC_EQ:     taken_o = flags_i.eq;
      CC_GTU:    taken_o = flags_i.gtu;
      CC_GEU:    taken_o = flags_i.gtu || flags_i.eq;
      CC_GTS:    taken_o = flags_i.gts;
      CC_GES:    taken_o = flags_i.gts || flags_i.eq;
      default:   bad_o   = 1'b1;
    endcase
  end

endmodule

// File: rtl/brcond_unit.sv
module brcond_unit
  import brcond_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              eval_i,
  input  logic              use_imm_i,
  input  logic [COND_W-1:0] cond_i,
  input  logic [DATA_W-1:0] rs1_i,
  input  logic [DATA_W-1:0] rs2_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [ADDR_W-1:0] ip_i,
  input  logic [ADDR_W-1:0] jump_addr_i,
  output logic              taken_o,
  output logic [ADDR_W-1:0] next_ip_o,
  output logic              cond_bad_o,
  output logic              taken_q_o
);

  localparam logic [ADDR_W-1:0] IP_STEP = {{(ADDR_W-1){1'b0}}, 1'b1};

  logic [DATA_W-1:0] opb;
  cmp_flags_t        flags;
  logic              taken_c;

  brcond_opsel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opsel (
    .use_imm_i (use_imm_i),
    .rs2_i     (rs2_i),
    .imm_i     (imm_i),
    .opb_o     (opb)
  );

  brcond_cmp #(.DATA_W(DATA_W)) u_cmp (
    .opa_i   (rs1_i),
    .opb_i   (opb),
    .flags_o (flags)
  );

  brcond_sel u_sel (
    .cond_i  (cond_i),
    .flags_i (flags),
    .taken_o (taken_c),
    .bad_o   (cond_bad_o)
  );

  assign taken_o   = taken_c;
  assign next_ip_o = taken_c ? jump_addr_i : (ip_i + IP_STEP);

  always_ff @(posedge clk) begin
    if (rst) begin
      taken_q_o <= 1'b0;
    end else begin
      taken_q_o <= eval_i && taken_c;
    end
  end

endmodule

// File: rtl/brcond_unit_chk.sv
module brcond_unit_chk
  import brcond_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              eval_i,
  input logic              use_imm_i,
  input logic [COND_W-1:0] cond_i,
  input logic [DATA_W-1:0] rs1_i,
  input logic [DATA_W-1:0] rs2_i,
  input logic [IMM_W-1:0]  imm_i,
  input logic [ADDR_W-1:0] ip_i,
  input logic [ADDR_W-1:0] jump_addr_i,
  input logic              taken_o,
  input logic [ADDR_W-1:0] next_ip_o,
  input logic              cond_bad_o,
  input logic              taken_q_o
);

  logic [DATA_W-1:0] imm_wide;
  assign imm_wide = DATA_W'($signed(imm_i));

  p_always_r1: assert property (@(posedge clk) disable iff (rst)
    (cond_i == 4'h0) |-> taken_o);

  p_eq_reg_r2: assert property (@(posedge clk) disable iff (rst)
    (cond_i == 4'h2 && !use_imm_i && rs1_i == rs2_i) |-> taken_o);

  p_geu_equal_r3: assert property (@(posedge clk) disable iff (rst)
    (cond_i == 4'h4 && !use_imm_i && rs1_i == rs2_i) |-> taken_o);

  p_eq_imm_r5: assert property (@(posedge clk) disable iff (rst)
    (cond_i == 4'h2 && use_imm_i && rs1_i == imm_wide) |-> taken_o);

  p_undef_never_r6: assert property (@(posedge clk) disable iff (rst)
    cond_bad_o |-> !taken_o);

  p_target_r7: assert property (@(posedge clk) disable iff (rst)
    taken_o |-> (next_ip_o == jump_addr_i));

  p_fallthru_r7: assert property (@(posedge clk) disable iff (rst)
    !taken_o |-> (next_ip_o == ip_i + 1'b1));

  p_reg_set_r8: assert property (@(posedge clk) disable iff (rst)
    (eval_i && taken_o) |=> taken_q_o);

  p_reg_clr_r8: assert property (@(posedge clk) disable iff (rst)
    !(eval_i && taken_o) |=> !taken_q_o);

  p_reset_r8: assert property (@(posedge clk)
    rst |=> !taken_q_o);

endmodule

bind brcond_unit brcond_unit_chk #(
  .DATA_W (DATA_W),
  .IMM_W  (IMM_W),
  .ADDR_W (ADDR_W)
) u_chk (.*);

// File: tb/brcond_unit_bench.sv
`timescale 1ns/1ps
module brcond_unit_bench;

  localparam int DATA_W = 32;
  localparam int IMM_W  = 16;
  localparam int ADDR_W = 32;
  localparam int NVEC   = 22;
  localparam int VW     = 91;

  // {cond[4], use_imm, rs1[32], rs2[32], imm[16], exp_taken, exp_bad, req[4]}
  localparam logic [VW-1:0] VECS [0:NVEC-1] = '{
    {4'h0, 1'b0, 32'h0000_0000, 32'h0000_0000, 16'h0000, 1'b1, 1'b0, 4'd1}, // R1
    {4'h0, 1'b1, 32'h0000_0005, 32'h0000_0000, 16'h0003, 1'b1, 1'b0, 4'd1}, // R1
    {4'h1, 1'b0, 32'h0000_0007, 32'h0000_0007, 16'h0000, 1'b0, 1'b0, 4'd2}, // R2
    {4'h1, 1'b0, 32'h0000_0007, 32'h0000_0008, 16'h0000, 1'b1, 1'b0, 4'd2}, // R2
    {4'h2, 1'b0, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 16'h0000, 1'b1, 1'b0, 4'd2}, // R2
    {4'h2, 1'b0, 32'h0000_0001, 32'h8000_0001, 16'h0000, 1'b0, 1'b0, 4'd2}, // R2
    {4'h3, 1'b0, 32'h8000_0000, 32'h7FFF_FFFF, 16'h0000, 1'b1, 1'b0, 4'd3}, // R3
    {4'h3, 1'b0, 32'h0000_0005, 32'h0000_0005, 16'h0000, 1'b0, 1'b0, 4'd3}, // R3
    {4'h4, 1'b0, 32'h0000_0005, 32'h0000_0005, 16'h0000, 1'b1, 1'b0, 4'd3}, // R3
    {4'h4, 1'b0, 32'h0000_0004, 32'h0000_0005, 16'h0000, 1'b0, 1'b0, 4'd3}, // R3
    {4'hC, 1'b0, 32'h8000_0000, 32'h7FFF_FFFF, 16'h0000, 1'b0, 1'b0, 4'd4}, // R4
    {4'hC, 1'b0, 32'h7FFF_FFFF, 32'h8000_0000, 16'h0000, 1'b1, 1'b0, 4'd4}, // R4
    {4'hD, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'h0000, 1'b1, 1'b0, 4'd4}, // R4
    {4'hD, 1'b0, 32'hFFFF_FFFE, 32'hFFFF_FFFF, 16'h0000, 1'b0, 1'b0, 4'd4}, // R4
    {4'h2, 1'b1, 32'hFFFF_8000, 32'h0000_0000, 16'h8000, 1'b1, 1'b0, 4'd5}, // R5
    {4'h3, 1'b1, 32'h0001_0000, 32'h0000_0000, 16'hFFFF, 1'b0, 1'b0, 4'd5}, // R5
    {4'hC, 1'b1, 32'h0000_0000, 32'h0000_0000, 16'hFFFF, 1'b1, 1'b0, 4'd5}, // R5
    {4'h2, 1'b1, 32'h0000_0007, 32'h0000_0007, 16'h0008, 1'b0, 1'b0, 4'd5}, // R5
    {4'h5, 1'b0, 32'h0000_0001, 32'h0000_0001, 16'h0000, 1'b0, 1'b1, 4'd6}, // R6
    {4'hB, 1'b0, 32'h0000_0000, 32'h0000_0000, 16'h0000, 1'b0, 1'b1, 4'd6}, // R6
    {4'hE, 1'b1, 32'h0000_0009, 32'h0000_0000, 16'h0001, 1'b0, 1'b1, 4'd6}, // R6
    {4'hF, 1'b0, 32'hFFFF_FFFF, 32'h0000_0000, 16'h0000, 1'b0, 1'b1, 4'd6}  // R6
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              eval_i = 1'b0;
  logic              use_imm_i = 1'b0;
  logic [3:0]        cond_i = 4'h0;
  logic [DATA_W-1:0] rs1_i = '0;
  logic [DATA_W-1:0] rs2_i = '0;
  logic [IMM_W-1:0]  imm_i = '0;
  logic [ADDR_W-1:0] ip_i = '0;
  logic [ADDR_W-1:0] jump_addr_i = '0;
  logic              taken_o;
  logic [ADDR_W-1:0] next_ip_o;
  logic              cond_bad_o;
  logic              taken_q_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  brcond_unit #(.DATA_W(DATA_W), .IMM_W(IMM_W), .ADDR_W(ADDR_W)) u_brcond_unit (
    .clk, .rst, .eval_i, .use_imm_i, .cond_i, .rs1_i, .rs2_i, .imm_i,
    .ip_i, .jump_addr_i, .taken_o, .next_ip_o, .cond_bad_o, .taken_q_o
  );

  function automatic string tag(input int n);
    case (n)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      6: return "R6";
      7: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL R8 watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // reset with a would-be-taken evaluation held at the inputs: R8
    eval_i = 1'b1;
    cond_i = 4'h0;
    repeat (3) @(negedge clk);
    check("R8", "taken_q during reset", {63'd0, taken_q_o}, 64'd0);
    rst = 1'b0;

    // vector table: R1..R7 combinational, R8 registered
    for (int i = 0; i < NVEC; i++) begin
      logic [VW-1:0] v;
      logic [ADDR_W-1:0] exp_ip;
      v = VECS[i];
      @(negedge clk);
      cond_i      = v[90:87];
      use_imm_i   = v[86];
      rs1_i       = v[85:54];
      rs2_i       = v[53:22];
      imm_i       = v[21:6];
      ip_i        = 32'h0000_0100 + 32'(i);
      jump_addr_i = 32'h0000_A000 + 32'(i);
      eval_i      = 1'b1;
      #1;
      exp_ip = v[5] ? jump_addr_i : ip_i + 1;
      check(tag(int'(v[3:0])), $sformatf("taken vec %0d", i), {63'd0, taken_o}, {63'd0, v[5]});
      check("R6", $sformatf("cond_bad vec %0d", i), {63'd0, cond_bad_o}, {63'd0, v[4]});
      check("R7", $sformatf("next_ip vec %0d", i), {32'd0, next_ip_o}, {32'd0, exp_ip});
      @(negedge clk);
      check("R8", $sformatf("taken_q vec %0d", i), {63'd0, taken_q_o}, {63'd0, v[5]});
    end

    // R7: fall-through wraps at the top of the address space
    @(negedge clk);
    cond_i = 4'h1; use_imm_i = 1'b0; rs1_i = 32'd3; rs2_i = 32'd3;
    ip_i = 32'hFFFF_FFFF; jump_addr_i = 32'h1234_5678;
    #1;
    check("R7", "wrap next_ip", {32'd0, next_ip_o}, 64'd0);

    // R8: taken condition without eval strobe leaves the register clear
    @(negedge clk);
    cond_i = 4'h0; eval_i = 1'b0;
    @(negedge clk);
    check("R8", "no eval", {63'd0, taken_q_o}, 64'd0);

    // R8: set, then synchronous reset clears it
    eval_i = 1'b1;
    @(negedge clk);
    check("R8", "eval taken", {63'd0, taken_q_o}, 64'd1);
    rst = 1'b1;
    @(negedge clk);
    check("R8", "reset clears", {63'd0, taken_q_o}, 64'd0);
    rst = 1'b0;

    // R5: rs2 equal to rs1 but immediate differs, signed test
    @(negedge clk);
    cond_i = 4'hD; use_imm_i = 1'b1; rs1_i = 32'hFFFF_FFF0;
    rs2_i = 32'hFFFF_FFF0; imm_i = 16'hFFFF;
    #1;
    check("R5", "rs2 ignored", {63'd0, taken_o}, 64'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule